// File: doc/BRIEF.md
# Parallel 3x3 Event Centroiding Engine

This block locates isolated bright events in a raster image stream and measures where each one sits inside its pixel. Pixels arrive in raster order as 64-bit words of eight 8-bit values, one word per accepted clock. Two internal line stores keep the two preceding rows. A two-column slab saved from the previous word is combined with the three-row column stack of the current word, which gives eight overlapping 3x3 neighbourhoods on every accepted word.

Each neighbourhood is tested in parallel. The centre pixel must be above a programmable discrimination level, and it must also be the peak of its box under a tie rule that reports only one event for a flat top. For each valid event a truncated three-point centre of gravity is computed on both axes and quantised to 1/32 pixel by a pipelined restoring divider. The results leave the block as a per-lane valid mask, with signed 5-bit X and Y offsets per lane and the row and word position of the window set.

Top module: `centroid3x3_engine`

## Requirements
- R1: Lane k of `in_pix` carries bits [8k+7:8k], and word w of a row covers columns 8w to 8w+7. Output lane k reported with `ev_word` = w and `ev_row` = y describes the event centred at row y, column 8w+k-1. No event is reported at any other position.
- R2: The outputs for the eight windows completed by the word of row r, word w that is accepted on clock edge t appear after edge t+5, with `ev_row` = r-1 and `ev_word` = w.
- R3: A lane is valid only when its centre b is above `disc_level`, is at least as large as its upper-left, upper, upper-right and left neighbours, and is strictly larger than its right, lower-left, lower and lower-right neighbours.
- R4: Two adjacent equal peak pixels, horizontal or vertical, give exactly one event: the one later in scan order.
- R5: No event is reported with its centre in the first or last row or column of the frame.
- R6: The centroid starts only when three rows are present. No word of row 0 or row 1 yields an event.
- R7: For a valid lane, `ev_dx[5k+4:5k]` is the two's complement value of 32*(c-a)/(a+b+c) truncated toward zero. Here a and c are the left and right neighbours of centre b. When a equals b and c is 0, the value is -16.
- R8: For a valid lane, `ev_dy[5k+4:5k]` follows the same rule, with a the pixel above and c the pixel below the centre.
- R9: A word with `in_sof` high and `in_valid` high is row 0, word 0. After reset, and after ROWS complete rows, words are ignored and produce no events until the next such word.
- R10: Reset clears `ev_valid`. A clock with `in_valid` low produces an all-zero `ev_valid` five clocks later and does not advance the row or word position.
- R11: The discrimination test is strict. A centre equal to `disc_level` yields no event, and a centre one above it does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word accepted this clock |
| in_sof | input | 1 | Marks the first word of a frame |
| in_pix | input | 64 | Eight 8-bit pixels, lane 0 leftmost |
| disc_level | input | 8 | Discrimination level |
| ev_valid | output | 8 | Per-lane event flag |
| ev_dx | output | 40 | Per-lane signed 5-bit X offset, 1/32 pixel |
| ev_dy | output | 40 | Per-lane signed 5-bit Y offset, 1/32 pixel |
| ev_row | output | $clog2(ROWS+1) | Centre row of the reported window set |
| ev_word | output | $clog2(WORDS) | Word index of the reported window set |

## Verification
Peak validation and the centroid divide run together on the same window in the same cycle. One lane's centroid must therefore line up with its own valid flag, while its neighbour lane is being rejected by the tie rule or the border rule. This is provoked with equal-valued pixel pairs and exact half-pixel ratios placed across word boundaries, and with idle gaps in the input. The bench judges every reported event against a model of the whole frame built from the requirements, comparing position, both offsets and the arrival clock. Any event at a position the model rejects counts as a failure.

// File: rtl/cg_pkg.sv
package cg_pkg;

    localparam int PIX_W  = 8;
    localparam int LANES  = 8;
    localparam int FRAC_W = 5;
    localparam int SUM_W  = PIX_W + 2;

    typedef logic [PIX_W-1:0] pix_t;

    // one column of three pixels: [0] upper row, [1] centre row, [2] lower row
    typedef logic [2:0][PIX_W-1:0] col3_t;

    typedef struct packed {
        logic             neg;
        logic [SUM_W-1:0] num;
        logic [SUM_W-1:0] den;
    } axis_t;

    typedef struct packed {
        logic        v;
        axis_t       ax_x;
        axis_t       ax_y;
    } lane_t;

    typedef struct packed {
        logic              neg;
        logic [SUM_W-1:0]  rem;
        logic [SUM_W-1:0]  den;
        logic [FRAC_W-1:0] q;
    } divst_t;

    function automatic axis_t prep_axis(pix_t a, pix_t b, pix_t c);
        axis_t r;
        r.neg = (a > c);
        r.num = (a > c) ? SUM_W'(a - c) : SUM_W'(c - a);
        r.den = SUM_W'(a) + SUM_W'(b) + SUM_W'(c);
        return r;
    endfunction

    function automatic divst_t div_init(axis_t ax);
        divst_t s;
        s.neg = ax.neg;
        s.rem = ax.num;
        s.den = ax.den;
        s.q   = '0;
        return s;
    endfunction

    // one restoring step: doubles the remainder and produces one quotient bit
    function automatic divst_t div_step(divst_t s);
        divst_t      r;
        logic [SUM_W:0] r2;
        logic        bit_q;
        r     = s;
        r2    = {s.rem, 1'b0};
        bit_q = (r2 >= {1'b0, s.den});
        if (bit_q)
            r.rem = SUM_W'(r2 - {1'b0, s.den});
        else
            r.rem = r2[SUM_W-1:0];
        r.q = (s.q << 1) | FRAC_W'(bit_q);
        return r;
    endfunction

    function automatic logic [FRAC_W-1:0] apply_sign(logic neg, logic [FRAC_W-1:0] q);
        return neg ? (~q + FRAC_W'(1)) : q;
    endfunction

endpackage

// File: rtl/cg_rowbuf.sv
module cg_rowbuf
    import cg_pkg::*;
#(
    parameter int WORDS = 128,
    parameter int ROWS  = 1024,
    localparam int CW   = $clog2(WORDS),
    localparam int RW   = $clog2(ROWS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic [LANES*PIX_W-1:0] in_pix,
    output col3_t [LANES+1:0]      win,
    output logic                   live,
    output logic [RW-1:0]          pos_row,
    output logic [CW-1:0]          pos_word
);

    logic [LANES*PIX_W-1:0] lb_near [WORDS];
    logic [LANES*PIX_W-1:0] lb_far  [WORDS];
    logic [CW-1:0]          word_q, eff_word;
    logic [RW-1:0]          row_q, eff_row;
    col3_t                  prev_a, prev_b;
    logic                   accept;

    always_comb begin
        eff_word = in_sof ? '0 : word_q;
        eff_row  = in_sof ? '0 : row_q;
        accept   = in_valid && (eff_row < RW'(ROWS));
    end

    // position counters; row_q == ROWS means no frame open
    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= RW'(ROWS);
            word_q <= '0;
        end else if (accept) begin
            if (eff_word == CW'(WORDS - 1)) begin
                word_q <= '0;
                row_q  <= eff_row + RW'(1);
            end else begin
                word_q <= eff_word + CW'(1);
                row_q  <= eff_row;
            end
        end
    end

    // two line stores act as a per-word vertical shift
    always_ff @(posedge clk) begin
        if (accept) begin
            lb_near[eff_word] <= in_pix;
            lb_far[eff_word]  <= lb_near[eff_word];
            prev_a            <= win[LANES];
            prev_b            <= win[LANES+1];
        end
    end

    assign win[0] = prev_a;
    assign win[1] = prev_b;

    for (genvar j = 0; j < LANES; j++) begin : g_col
        assign win[j+2][0] = lb_far[eff_word][j*PIX_W +: PIX_W];
        assign win[j+2][1] = lb_near[eff_word][j*PIX_W +: PIX_W];
        assign win[j+2][2] = in_pix[j*PIX_W +: PIX_W];
    end

    assign live     = accept && (eff_row >= RW'(2));
    assign pos_row  = eff_row - RW'(1);
    assign pos_word = eff_word;

endmodule

// File: rtl/cg_lane.sv
module cg_lane
    import cg_pkg::*;
(
    input  col3_t col_l,
    input  col3_t col_m,
    input  col3_t col_r,
    input  logic  gate,
    input  pix_t  thr,
    output lane_t res
);

    pix_t b;
    logic before_ok, after_ok;

    always_comb begin
        b = col_m[1];
        // neighbours already scanned accept ties, later ones do not
        before_ok = (b >= col_l[0]) && (b >= col_m[0]) && (b >= col_r[0]) && (b >= col_l[1]);
        after_ok  = (b >  col_r[1]) && (b >  col_l[2]) && (b >  col_m[2]) && (b >  col_r[2]);
        res.v     = gate && (b > thr) && before_ok && after_ok;
        res.ax_x  = prep_axis(col_l[1], b, col_r[1]);
        res.ax_y  = prep_axis(col_m[0], b, col_m[2]);
    end

endmodule

// File: rtl/cg_divider.sv
module cg_divider
    import cg_pkg::*;
(
    input  logic              clk,
    input  axis_t             ax_in,
    output logic [FRAC_W-1:0] frac
);

    divst_t            st [FRAC_W-1];
    logic              neg_q;
    logic [FRAC_W-1:0] q_q;
    divst_t            last;

    for (genvar i = 0; i < FRAC_W - 1; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) st[i] <= div_step(div_init(ax_in));
        end else begin : g_next
            always_ff @(posedge clk) st[i] <= div_step(st[i-1]);
        end
    end

    assign last = div_step(st[FRAC_W-2]);

    always_ff @(posedge clk) begin
        neg_q <= last.neg;
        q_q   <= last.q;
    end

    assign frac = apply_sign(neg_q, q_q);

endmodule

// File: rtl/centroid3x3_engine.sv
module centroid3x3_engine
    import cg_pkg::*;
#(
    parameter int WORDS = 128,
    parameter int ROWS  = 1024,
    localparam int CW   = $clog2(WORDS),
    localparam int RW   = $clog2(ROWS + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic [LANES*PIX_W-1:0]  in_pix,
    input  logic [PIX_W-1:0]        disc_level,
    output logic [LANES-1:0]        ev_valid,
    output logic [LANES*FRAC_W-1:0] ev_dx,
    output logic [LANES*FRAC_W-1:0] ev_dy,
    output logic [RW-1:0]           ev_row,
    output logic [CW-1:0]           ev_word
);

    col3_t [LANES+1:0]     win;
    logic                  live;
    logic [RW-1:0]         pos_row;
    logic [CW-1:0]         pos_word;
    lane_t [LANES-1:0]     lane_c;
    lane_t [LANES-1:0]     s1;
    logic [RW-1:0]         s1_row;
    logic [CW-1:0]         s1_word;
    logic [LANES-1:0]      s1_v;
    logic [FRAC_W-1:0][LANES-1:0] vpipe;
    logic [FRAC_W-1:0][RW-1:0]    rpipe;
    logic [FRAC_W-1:0][CW-1:0]    wpipe;

    cg_rowbuf #(.WORDS(WORDS), .ROWS(ROWS)) rowbuf_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_pix   (in_pix),
        .win      (win),
        .live     (live),
        .pos_row  (pos_row),
        .pos_word (pos_word)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic gate;
        if (k < 2) begin : g_edge
            // centres in column -1 and column 0 of word 0 are frame border
            assign gate = live && (pos_word != '0);
        end else begin : g_inner
            assign gate = live;
        end

        cg_lane lane_i (
            .col_l (win[k]),
            .col_m (win[k+1]),
            .col_r (win[k+2]),
            .gate  (gate),
            .thr   (disc_level),
            .res   (lane_c[k])
        );

        assign s1_v[k] = s1[k].v;

        cg_divider div_x_i (
            .clk   (clk),
            .ax_in (s1[k].ax_x),
            .frac  (ev_dx[k*FRAC_W +: FRAC_W])
        );

        cg_divider div_y_i (
            .clk   (clk),
            .ax_in (s1[k].ax_y),
            .frac  (ev_dy[k*FRAC_W +: FRAC_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= '0;
            s1_row  <= '0;
            s1_word <= '0;
        end else begin
            s1      <= lane_c;
            s1_row  <= pos_row;
            s1_word <= pos_word;
        end
    end

    // flags and position travel beside the divider stages
    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe <= '0;
            rpipe <= '0;
            wpipe <= '0;
        end else begin
            vpipe <= {vpipe[FRAC_W-2:0], s1_v};
            rpipe <= {rpipe[FRAC_W-2:0], s1_row};
            wpipe <= {wpipe[FRAC_W-2:0], s1_word};
        end
    end

    assign ev_valid = vpipe[FRAC_W-1];
    assign ev_row   = rpipe[FRAC_W-1];
    assign ev_word  = wpipe[FRAC_W-1];

endmodule

// File: rtl/cg_checker.sv
module cg_checker
    import cg_pkg::*;
#(
    parameter int WORDS = 128,
    parameter int ROWS  = 1024,
    localparam int CW   = $clog2(WORDS),
    localparam int RW   = $clog2(ROWS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [LANES-1:0] ev_valid,
    input logic [RW-1:0]    ev_row,
    input logic [CW-1:0]    ev_word
);

    logic [FRAC_W:0] vh;

    always_ff @(posedge clk) begin
        if (rst) vh <= '0;
        else     vh <= {vh[FRAC_W-1:0], in_valid};
    end

    // R4: two neighbouring centres can never both be peaks
    assert_no_adjacent_R4: assert property (@(posedge clk) disable iff (rst)
        (ev_valid & (ev_valid >> 1)) == '0);

    // R5: lanes 0 and 1 of word 0 sit on column -1 and column 0
    assert_border_col_R5: assert property (@(posedge clk) disable iff (rst)
        (ev_word == '0) |-> (ev_valid[1:0] == 2'b00));

    // R5: reported rows stay inside the frame interior
    assert_border_row_R5: assert property (@(posedge clk) disable iff (rst)
        (|ev_valid) |-> ((ev_row >= RW'(1)) && (ev_row <= RW'(ROWS - 2))));

    // R2: every event stems from a word accepted five clocks before
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (|ev_valid) |-> vh[FRAC_W]);

    // R10: reset leaves the flags clear
    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ev_valid == '0));

endmodule

bind centroid3x3_engine cg_checker #(.WORDS(WORDS), .ROWS(ROWS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .ev_valid (ev_valid),
    .ev_row   (ev_row),
    .ev_word  (ev_word)
);

// File: tb/centroid3x3_engine_tb_top.sv
`timescale 1ns/1ps
module centroid3x3_engine_tb_top;

    localparam int WORDS = 4;
    localparam int ROWS  = 6;
    localparam int W     = WORDS * 8;
    localparam int CW    = $clog2(WORDS);
    localparam int RW    = $clog2(ROWS + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_sof = 1'b0;
    logic [63:0]   in_pix = '0;
    logic [7:0]    disc_level = 8'd30;
    logic [7:0]    ev_valid;
    logic [39:0]   ev_dx, ev_dy;
    logic [RW-1:0] ev_row;
    logic [CW-1:0] ev_word;

    centroid3x3_engine #(.WORDS(WORDS), .ROWS(ROWS)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_pix     (in_pix),
        .disc_level (disc_level),
        .ev_valid   (ev_valid),
        .ev_dx      (ev_dx),
        .ev_dy      (ev_dy),
        .ev_row     (ev_row),
        .ev_word    (ev_word)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int img   [ROWS][W];
    int acc_t [ROWS][WORDS];
    bit got_v [ROWS][W];
    int got_dx[ROWS][W];
    int got_dy[ROWS][W];
    int got_t [ROWS][W];
    int n_events = 0;
    int stray    = 0;

    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < 8; k++) begin
                if (ev_valid[k]) begin
                    int x, y;
                    x = 8 * int'(ev_word) + k - 1;
                    y = int'(ev_row);
                    if (x >= 0 && x < W && y >= 0 && y < ROWS && !got_v[y][x]) begin
                        got_v[y][x]  = 1'b1;
                        got_dx[y][x] = int'($signed(ev_dx[5*k +: 5]));
                        got_dy[y][x] = int'($signed(ev_dy[5*k +: 5]));
                        got_t[y][x]  = cyc;
                        n_events++;
                    end else begin
                        stray++;
                    end
                end
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    task automatic clear_all();
        for (int y = 0; y < ROWS; y++)
            for (int x = 0; x < W; x++) begin
                img[y][x]   = 0;
                got_v[y][x] = 0;
            end
        n_events = 0;
        stray    = 0;
    endtask

    task automatic put_word(bit v, bit s, logic [63:0] d);
        @(posedge clk);
        #1;
        in_valid = v;
        in_sof   = s;
        in_pix   = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) put_word(1'b0, 1'b0, '0);
    endtask

    function automatic logic [63:0] pack(int y, int w);
        logic [63:0] d;
        for (int k = 0; k < 8; k++) d[8*k +: 8] = 8'(img[y][8*w + k]);
        return d;
    endfunction

    task automatic send_frame(bit sof, bit gaps);
        for (int y = 0; y < ROWS; y++)
            for (int w = 0; w < WORDS; w++) begin
                put_word(1'b1, sof && y == 0 && w == 0, pack(y, w));
                acc_t[y][w] = cyc + 1;
                if (gaps && (w == 1 || (y == 3 && w == 2))) put_word(1'b0, 1'b0, '0);
            end
        idle(10);
    endtask

    function automatic bit exp_valid(int y, int x);
        int b;
        if (y < 1 || y > ROWS - 2 || x < 1 || x > W - 2) return 0;
        b = img[y][x];
        if (b <= int'(disc_level)) return 0;
        if (b < img[y-1][x-1] || b < img[y-1][x] || b < img[y-1][x+1] || b < img[y][x-1]) return 0;
        if (b <= img[y][x+1] || b <= img[y+1][x-1] || b <= img[y+1][x] || b <= img[y+1][x+1]) return 0;
        return 1;
    endfunction

    function automatic int exp_off(int a, int b, int c);
        int n, m;
        n = c - a;
        m = ((n < 0 ? -n : n) * 32) / (a + b + c);
        return (n < 0) ? -m : m;
    endfunction

    // compares every reported event against the frame model
    task automatic check_frame(string scen);
        int unexp;
        unexp = 0;
        for (int y = 0; y < ROWS; y++)
            for (int x = 0; x < W; x++) begin
                if (exp_valid(y, x)) begin
                    chk(got_v[y][x], "R3", {scen, " event present"}, int'(got_v[y][x]), 1);
                    if (got_v[y][x]) begin
                        chk(got_dx[y][x] == exp_off(img[y][x-1], img[y][x], img[y][x+1]),
                            "R7", {scen, " x offset"}, got_dx[y][x],
                            exp_off(img[y][x-1], img[y][x], img[y][x+1]));
                        chk(got_dy[y][x] == exp_off(img[y-1][x], img[y][x], img[y+1][x]),
                            "R8", {scen, " y offset"}, got_dy[y][x],
                            exp_off(img[y-1][x], img[y][x], img[y+1][x]));
                        chk(got_t[y][x] == acc_t[y+1][(x+1)/8] + 5, "R2", {scen, " latency"},
                            got_t[y][x], acc_t[y+1][(x+1)/8] + 5);
                    end
                end else if (got_v[y][x]) begin
                    unexp++;
                end
            end
        chk(unexp + stray == 0, "R1", {scen, " events only at valid positions"}, unexp + stray, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ev_valid == 8'h00, "R10", "flags clear during reset", int'(ev_valid), 0);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(ev_valid == 8'h00, "R10", "flags clear after reset", int'(ev_valid), 0);
    endtask

    task automatic t_no_sof();
        clear_all();
        img[2][10] = 200;
        send_frame(1'b0, 1'b0);
        chk(n_events + stray == 0, "R9", "frame without start marker ignored", n_events + stray, 0);
    endtask

    task automatic t_spots();
        clear_all();
        disc_level = 8'd30;
        img[2][10] = 200; img[2][9] = 40; img[2][11] = 100; img[1][10] = 60; img[3][10] = 20;
        img[1][9] = 10; img[3][11] = 10;
        img[2][7] = 180; img[2][6] = 90; img[2][8] = 25; img[1][7] = 5; img[3][7] = 70;
        img[3][16] = 250; img[3][15] = 3; img[3][17] = 200; img[2][16] = 100; img[4][16] = 100;
        send_frame(1'b1, 1'b0);
        check_frame("spots");
        chk(n_events == 3, "R3", "three isolated peaks found", n_events, 3);
        chk(got_v[2][7] && got_v[3][16], "R1", "peaks across word boundaries", int'(got_v[2][7]), 1);
    endtask

    task automatic t_threshold();
        clear_all();
        disc_level = 8'd100;
        img[2][10] = 100;
        img[3][20] = 101; img[3][19] = 50;
        send_frame(1'b1, 1'b0);
        check_frame("threshold");
        chk(n_events == 1, "R11", "only the centre above the level counts", n_events, 1);
        chk(!got_v[2][10], "R11", "centre equal to level rejected", int'(got_v[2][10]), 0);
        disc_level = 8'd30;
    endtask

    task automatic t_plateau();
        clear_all();
        img[2][5] = 150; img[2][6] = 150;
        img[3][20] = 150; img[4][20] = 150;
        send_frame(1'b1, 1'b0);
        check_frame("plateau");
        chk(n_events == 2, "R4", "one event per flat pair", n_events, 2);
        chk(got_v[2][6] && got_v[4][20], "R4", "later pixel of each pair reported",
            int'(got_v[2][6]) + int'(got_v[4][20]), 2);
    endtask

    task automatic t_border();
        clear_all();
        img[0][10] = 200; img[5][14] = 200; img[3][0] = 200; img[2][31] = 200;
        img[1][1] = 220; img[4][30] = 210;
        send_frame(1'b1, 1'b0);
        check_frame("border");
        chk(n_events == 2, "R5", "only interior peaks reported", n_events, 2);
        chk(got_v[1][1] && got_v[4][30], "R5", "first and last interior cells", n_events, 2);
        chk(!got_v[0][10], "R6", "no event centred in row 0", int'(got_v[0][10]), 0);
    endtask

    task automatic t_half();
        clear_all();
        img[2][12] = 120; img[2][11] = 120; img[1][12] = 120;
        img[3][25] = 200; img[3][26] = 199; img[3][24] = 0;
        send_frame(1'b1, 1'b0);
        check_frame("half");
        chk(got_dx[2][12] == -16, "R7", "x offset at minus one half", got_dx[2][12], -16);
        chk(got_dy[2][12] == -16, "R8", "y offset at minus one half", got_dy[2][12], -16);
        chk(got_dx[3][25] == 15, "R7", "largest positive x offset", got_dx[3][25], 15);
    endtask

    task automatic t_gaps();
        clear_all();
        img[3][9] = 210; img[3][10] = 60; img[4][9] = 33;
        send_frame(1'b1, 1'b1);
        check_frame("gaps");
        chk(n_events == 1, "R10", "idle clocks do not move the position", n_events, 1);
    endtask

    task automatic t_after_frame();
        clear_all();
        img[2][10] = 200;
        send_frame(1'b1, 1'b0);
        chk(n_events == 1, "R9", "frame with start marker processed", n_events, 1);
        n_events = 0;
        for (int y = 0; y < ROWS; y++)
            for (int w = 0; w < WORDS; w++) put_word(1'b1, 1'b0, pack(y, w));
        idle(10);
        chk(n_events + stray == 0, "R9", "words after the last row ignored", n_events + stray, 0);
    endtask

    task automatic t_random();
        int unsigned s;
        s = 32'd12345;
        clear_all();
        disc_level = 8'd180;
        for (int y = 0; y < ROWS; y++)
            for (int x = 0; x < W; x++) begin
                s = s * 32'd1103515245 + 32'd12345;
                img[y][x] = int'((s >> 16) & 32'hFF);
            end
        send_frame(1'b1, 1'b0);
        check_frame("random");
        chk(n_events > 0, "R3", "random frame yields events", n_events, 1);
        disc_level = 8'd30;
    endtask

    initial begin
        t_reset();
        t_no_sof();
        t_spots();
        t_threshold();
        t_plateau();
        t_border();
        t_half();
        t_gaps();
        t_after_frame();
        t_random();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(8ns * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

endmodule